// File: doc/BRIEF.md
# Boot Address Remapper with Application Image Blank Check

This block sits in front of two on-chip nonvolatile banks: an application bank and a bootloader bank. It decides which of the two the processor sees at address zero. After synchronous reset is released it latches a boot strap input and waits a fixed settling interval. When the strap asks for the application, it also reads the first words of the application bank. An erased first word means no image is present, and the block then falls back to the bootloader. Only after that decision is made does it raise a ready flag, which holds the processor off until then. As a result the processor's first vector fetch at address zero already lands in the right bank.

Once ready is high, every request is decoded in the request cycle and answered one cycle later. The low boot window is served by the chosen bank. A direct window at 0x08000000 reaches either bank at any time, whatever the boot choice: address bit 24 picks the bank and the low bits give the word offset. Any other address returns an error flag with zero data. The two banks are behavioural word arrays that can infer block RAM. A load port fills them from outside.

Top module: `boot_remap`

## Requirements
- R1: The strap is latched on the first rising edge with reset low. Later changes on `boot_strap` do not change the mapping until the next reset.
- R2: Once ready, the boot window (byte addresses 0 to 4*2^BANK_AW-1, bits [31:BANK_AW+2] zero) is served by the application bank if the latched strap is 0 and the image is present. It is served by the bootloader bank if the latched strap is 1.
- R3: In the direct window (bits [31:25] equal 0000100), address bit 24 = 0 reads the application bank and bit 24 = 1 reads the bootloader bank. The word offset is bits [BANK_AW+1:2], and every other bit below 24 is ignored.
- R4: When the application bank serves the boot window, a read at offset X returns the same word as a read at 0x08000000+X.
- R5: With strap 0, application word 0 is checked. If it equals the erased value (all ones when ERASED_ONES=1, all zeros when 0), the boot window is served by the bootloader bank.
- R6: `cpu_ready` is 0 in reset. It rises after rising edge number SETTLE_CYC+1+CHECK_WORDS with reset low, counting the first such edge as edge 0; with strap 1 the CHECK_WORDS term is dropped. It then stays high until reset.
- R7: A request made while `cpu_ready` is 0 gives no response.
- R8: A ready request to any other address gives `rsp_valid`=1, `rsp_err`=1 and `rsp_data`=0.
- R9: A request accepted while ready is answered on the next rising edge with `rsp_valid`=1. No extra cycle is spent on the remap.
- R10: In the request cycle, `bank_sel_app` / `bank_sel_boot` show the bank being read and `remap_off` shows its word offset. At most one select is high, and both are low for unmapped or non-ready requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_strap | input | 1 | 0 = run application, 1 = run bootloader |
| cpu_req | input | 1 | Read request from the processor |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_ready | output | 1 | Mapping decided; processor may run |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_data | output | DATA_W | Read word, zero on error |
| rsp_err | output | 1 | Address hit no window |
| bank_sel_app | output | 1 | Request cycle reads the application bank |
| bank_sel_boot | output | 1 | Request cycle reads the bootloader bank |
| remap_off | output | BANK_AW | Word offset inside the selected bank |
| load_en | input | 1 | Write one word into a bank |
| load_sel_boot | input | 1 | 0 = application bank, 1 = bootloader bank |
| load_idx | input | BANK_AW | Word index to write |
| load_data | input | DATA_W | Word to write |

## Verification
The bench toggles the strap right after it is latched. A design that samples it live would swap banks partway through the run. Application word 0 is set valid, all ones and all zeros. These show whether the erased-state test is the wrong polarity or is skipped, which would boot an empty bank. The bench counts the exact edge on which ready rises for both strap values and issues requests before that edge: early release or a response to an early fetch shows up at once. Direct-window reads use high garbage bits and both values of bit 24, and near-miss addresses check that a loose decode cannot alias an unmapped area onto a bank.

// File: rtl/boot_remap_pkg.sv
package boot_remap_pkg;
  typedef enum logic [1:0] {
    RG_NONE    = 2'd0,
    RG_BOOT    = 2'd1,
    RG_APP_DIR = 2'd2,
    RG_LDR_DIR = 2'd3
  } region_e;

  typedef enum logic [2:0] {
    SQ_RESET  = 3'd0,
    SQ_SETTLE = 3'd1,
    SQ_CHECK  = 3'd2,
    SQ_FINISH = 3'd3,
    SQ_RUN    = 3'd4
  } seq_e;
endpackage

// File: rtl/nv_bank.sv
module nv_bank #(
  parameter int DATA_W = 32,
  parameter int AW     = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DATA_W-1:0] cells [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= cells[rd_idx];
  end
endmodule

// File: rtl/addr_decode.sv
module addr_decode
  import boot_remap_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int AW          = 6,
  parameter int DIR_SEL_BIT = 24,
  parameter int DIR_TAG     = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [AW-1:0]     off
);
  localparam int TOP_LO = AW + 2;
  localparam int TAG_W  = ADDR_W - DIR_SEL_BIT - 1;
  localparam logic [TAG_W-1:0] TAG = TAG_W'(DIR_TAG);

  logic boot_hit, dir_hit;
  logic unused_lo;

  assign unused_lo = ^addr[1:0];
  assign boot_hit  = (addr[ADDR_W-1:TOP_LO] == '0);
  assign dir_hit   = (addr[ADDR_W-1:DIR_SEL_BIT+1] == TAG);
  assign off       = addr[AW+1:2];

  always_comb begin
    if (boot_hit)                 region = RG_BOOT;
    else if (!dir_hit)            region = RG_NONE;
    else if (addr[DIR_SEL_BIT])   region = RG_LDR_DIR;
    else                          region = RG_APP_DIR;
  end
endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_remap_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int AW          = 6,
  parameter int SETTLE_CYC  = 16,
  parameter int CHECK_WORDS = 4,
  parameter bit ERASED_ONES = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap,
  input  logic [DATA_W-1:0] chk_word,
  output logic              chk_rd_en,
  output logic [AW-1:0]     chk_idx,
  output logic              ready,
  output logic              map_app
);
  // CHECK_WORDS must be at least 2: word 0 is judged one cycle after its read.
  localparam int CNT_W = $clog2(SETTLE_CYC + CHECK_WORDS + 1);
  localparam logic [DATA_W-1:0] ERASED = ERASED_ONES ? '1 : '0;

  seq_e             st;
  logic [CNT_W-1:0] cnt;
  logic             strap_q;
  logic             blank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SQ_RESET;
      cnt     <= '0;
      strap_q <= 1'b0;
      blank_q <= 1'b0;
      ready   <= 1'b0;
      map_app <= 1'b0;
    end else begin
      case (st)
        SQ_RESET: begin
          strap_q <= strap;
          cnt     <= '0;
          st      <= SQ_SETTLE;
        end
        SQ_SETTLE: begin
          if (cnt == CNT_W'(SETTLE_CYC - 1)) begin
            cnt <= '0;
            st  <= strap_q ? SQ_FINISH : SQ_CHECK;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        SQ_CHECK: begin
          cnt <= cnt + 1'b1;
          if (cnt == CNT_W'(1)) blank_q <= (chk_word == ERASED);
          if (cnt == CNT_W'(CHECK_WORDS - 1)) st <= SQ_FINISH;
        end
        SQ_FINISH: begin
          ready   <= 1'b1;
          map_app <= !strap_q && !blank_q;
          st      <= SQ_RUN;
        end
        default: st <= SQ_RUN;
      endcase
    end
  end

  assign chk_rd_en = (st == SQ_CHECK);
  assign chk_idx   = AW'(cnt);

  assert_ready_holds_R6: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (rst)
    ready |-> $stable(strap_q));
  assert_map_frozen_R2: assert property (@(posedge clk) disable iff (rst)
    ready |=> $stable(map_app));
  assert_no_check_after_ready_R5: assert property (@(posedge clk) disable iff (rst)
    ready |-> !chk_rd_en);
endmodule

// File: rtl/boot_remap.sv
module boot_remap
  import boot_remap_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 32,
  parameter int BANK_AW     = 6,
  parameter int SETTLE_CYC  = 16,
  parameter int CHECK_WORDS = 4,
  parameter bit ERASED_ONES = 1'b1,
  parameter int DIR_SEL_BIT = 24,
  parameter int DIR_TAG     = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               boot_strap,
  input  logic               cpu_req,
  input  logic [ADDR_W-1:0]  cpu_addr,
  output logic               cpu_ready,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_data,
  output logic               rsp_err,
  output logic               bank_sel_app,
  output logic               bank_sel_boot,
  output logic [BANK_AW-1:0] remap_off,
  input  logic               load_en,
  input  logic               load_sel_boot,
  input  logic [BANK_AW-1:0] load_idx,
  input  logic [DATA_W-1:0]  load_data
);
  localparam int NBANK = 2;

  region_e            region;
  logic [BANK_AW-1:0] off;
  logic               chk_rd_en, map_app, req_ok, go_app, go_ldr;
  logic [BANK_AW-1:0] chk_idx;
  logic               valid_q, err_q, from_ldr_q;

  logic [NBANK-1:0]   bk_rd_en;
  logic [BANK_AW-1:0] bk_rd_idx  [NBANK];
  logic [DATA_W-1:0]  bk_rd_data [NBANK];

  addr_decode #(
    .ADDR_W(ADDR_W), .AW(BANK_AW), .DIR_SEL_BIT(DIR_SEL_BIT), .DIR_TAG(DIR_TAG)
  ) u_dec (
    .addr(cpu_addr), .region(region), .off(off)
  );

  boot_seq #(
    .DATA_W(DATA_W), .AW(BANK_AW), .SETTLE_CYC(SETTLE_CYC),
    .CHECK_WORDS(CHECK_WORDS), .ERASED_ONES(ERASED_ONES)
  ) u_seq (
    .clk(clk), .rst(rst), .strap(boot_strap), .chk_word(bk_rd_data[0]),
    .chk_rd_en(chk_rd_en), .chk_idx(chk_idx), .ready(cpu_ready), .map_app(map_app)
  );

  assign req_ok = cpu_req && cpu_ready;
  assign go_app = req_ok && ((region == RG_BOOT && map_app)  || region == RG_APP_DIR);
  assign go_ldr = req_ok && ((region == RG_BOOT && !map_app) || region == RG_LDR_DIR);

  assign bank_sel_app  = go_app;
  assign bank_sel_boot = go_ldr;
  assign remap_off     = (go_app || go_ldr) ? off : '0;

  // Bank 0 is the application bank (also read by the sequencer), bank 1 the bootloader.
  assign bk_rd_en[0]  = go_app || chk_rd_en;
  assign bk_rd_idx[0] = cpu_ready ? off : chk_idx;
  assign bk_rd_en[1]  = go_ldr;
  assign bk_rd_idx[1] = off;

  for (genvar gb = 0; gb < NBANK; gb++) begin : g_bank
    nv_bank #(.DATA_W(DATA_W), .AW(BANK_AW)) u_bank (
      .clk(clk),
      .wr_en(load_en && (load_sel_boot == gb[0])),
      .wr_idx(load_idx),
      .wr_data(load_data),
      .rd_en(bk_rd_en[gb]),
      .rd_idx(bk_rd_idx[gb]),
      .rd_data(bk_rd_data[gb])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q    <= 1'b0;
      err_q      <= 1'b0;
      from_ldr_q <= 1'b0;
    end else begin
      valid_q    <= req_ok;
      err_q      <= req_ok && (region == RG_NONE);
      from_ldr_q <= go_ldr;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_err   = err_q;
  assign rsp_data  = (valid_q && !err_q) ? (from_ldr_q ? bk_rd_data[1] : bk_rd_data[0]) : '0;

  assert_sel_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({bank_sel_app, bank_sel_boot}));
  assert_quiet_unready_R7: assert property (@(posedge clk) disable iff (rst)
    !cpu_ready |=> !rsp_valid);
  assert_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_ready) |=> rsp_valid);
  assert_err_zero_R8: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_valid && rsp_data == '0));
  assert_err_no_bank_R8: assert property (@(posedge clk) disable iff (rst)
    (bank_sel_app || bank_sel_boot) |=> !rsp_err);
endmodule

// File: tb/test_boot_remap.sv
module test_boot_remap;
  localparam int AW = 6;
  localparam int WORDS = 1 << AW;
  localparam int SETTLE = 16;
  localparam int CHECKW = 4;
  localparam logic [31:0] ERASED = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst = 1'b1, boot_strap = 1'b0, cpu_req = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic cpu_ready, rsp_valid, rsp_err, bank_sel_app, bank_sel_boot;
  logic [31:0] rsp_data;
  logic [AW-1:0] remap_off;
  logic load_en = 1'b0, load_sel_boot = 1'b0;
  logic [AW-1:0] load_idx = '0;
  logic [31:0] load_data = '0;

  int n_cmp = 0, n_bad = 0, wd = 0;
  logic [31:0] app_m [WORDS];
  logic [31:0] ldr_m [WORDS];

  always #10 clk = ~clk;

  boot_remap i_boot_remap (
    .clk(clk), .rst(rst), .boot_strap(boot_strap), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
    .cpu_ready(cpu_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .bank_sel_app(bank_sel_app), .bank_sel_boot(bank_sel_boot), .remap_off(remap_off),
    .load_en(load_en), .load_sel_boot(load_sel_boot), .load_idx(load_idx), .load_data(load_data)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference decode: returns err, whether the bootloader bank is read, and the offset.
  function automatic void ref_map(input logic [31:0] a, input logic s,
                                  output bit err, output bit ldr, output logic [AW-1:0] o);
    o = a[AW+1:2];
    err = 1'b0; ldr = 1'b0;
    if (a[31:AW+2] == '0) ldr = !(s == 1'b0 && app_m[0] != ERASED);
    else if (a[31:25] == 7'd4) ldr = a[24];
    else err = 1'b1;
  endfunction

  // Behavioural reference, updated on every rising edge.
  bit m_seen = 0, m_ready = 0, m_valid = 0, m_err = 0, m_strap = 0;
  int m_edge = 0;
  logic [31:0] m_data = '0;
  int me; bit ms, merr, mldr; logic [AW-1:0] moff;

  always @(posedge clk) begin
    if (rst) begin
      m_seen <= 0; m_edge <= 0; m_ready <= 0; m_valid <= 0; m_err <= 0; m_data <= '0;
    end else begin
      me = m_seen ? m_edge + 1 : 0;
      ms = m_seen ? m_strap : boot_strap;
      if (!m_seen) m_strap <= boot_strap;
      m_seen <= 1; m_edge <= me;
      if (me == SETTLE + 1 + (ms ? 0 : CHECKW)) m_ready <= 1;
      ref_map(cpu_addr, ms, merr, mldr, moff);
      m_valid <= cpu_req && m_ready;
      m_err   <= cpu_req && m_ready && merr;
      m_data  <= (cpu_req && m_ready && !merr) ? (mldr ? ldr_m[moff] : app_m[moff]) : '0;
    end
  end

  bit chk_on = 0;
  bit cerr, cldr; logic [AW-1:0] coff; bit e_app, e_ldr;
  always @(posedge clk) if (rst) chk_on <= 1;

  always @(negedge clk) begin
    if (chk_on) begin
      check(cpu_ready === m_ready, "R6 ready", 32'(cpu_ready), 32'(m_ready));
      check(rsp_valid === m_valid, "R7/R9 rsp_valid", 32'(rsp_valid), 32'(m_valid));
      check(rsp_err === m_err, "R8 rsp_err", 32'(rsp_err), 32'(m_err));
      check(rsp_data === m_data, "R3 rsp_data", rsp_data, m_data);
      ref_map(cpu_addr, m_strap, cerr, cldr, coff);
      e_app = cpu_req && m_ready && !cerr && !cldr;
      e_ldr = cpu_req && m_ready && !cerr && cldr;
      check(bank_sel_app === e_app, "R10 bank_sel_app", 32'(bank_sel_app), 32'(e_app));
      check(bank_sel_boot === e_ldr, "R10 bank_sel_boot", 32'(bank_sel_boot), 32'(e_ldr));
      if (e_app || e_ldr)
        check(remap_off === coff, "R10 remap_off", 32'(remap_off), 32'(coff));
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic rd(input logic [31:0] a, output logic [31:0] d);
    @(posedge clk); #2; cpu_req = 1'b1; cpu_addr = a;
    @(posedge clk); #2; cpu_req = 1'b0;
    @(negedge clk); d = rsp_data;
  endtask

  task automatic run_case(input logic s, input logic [31:0] w0, input bit exp_app, input int sc);
    int n;
    logic [31:0] d, d2;
    @(posedge clk); #2; rst = 1'b1; boot_strap = s;
    for (int i = 0; i < WORDS; i++) begin
      app_m[i] = (i == 0) ? w0 : (32'hA500_0000 | (sc << 16) | (i * 4));
      ldr_m[i] = 32'hB000_0000 ^ (i * 32'h0101_0101) ^ sc;
    end
    for (int i = 0; i < 2 * WORDS; i++) begin
      load_en = 1'b1; load_sel_boot = (i >= WORDS);
      load_idx = AW'(i % WORDS);
      load_data = (i >= WORDS) ? ldr_m[i % WORDS] : app_m[i % WORDS];
      @(posedge clk); #2;
    end
    load_en = 1'b0;
    @(negedge clk);
    check(cpu_ready === 1'b0 && rsp_valid === 1'b0, "R6 reset state", 32'(cpu_ready), 32'd0);
    @(posedge clk); #2;
    rst = 1'b0; cpu_req = 1'b1; cpu_addr = 32'h0;   // early vector fetch, must be held off (R7)
    n = 0;
    while (cpu_ready !== 1'b1 && n < 100) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) boot_strap = ~s;                  // R1: change after latch has no effect
    end
    cpu_req = 1'b0;
    check(n == SETTLE + 2 + (s ? 0 : CHECKW), "R6 ready edge count", 32'(n), 32'(SETTLE + 2 + (s ? 0 : CHECKW)));
    rd(32'h0, d);
    check(d === (exp_app ? app_m[0] : ldr_m[0]), "R2/R5/R1 boot vector word", d, exp_app ? app_m[0] : ldr_m[0]);
    rd(32'h14, d);
    rd(exp_app ? 32'h0800_0014 : 32'h0900_0014, d2);
    check(d === d2, "R4 boot alias equals direct", d, d2);
    rd(32'h0800_0014, d);
    check(d === app_m[5], "R3 direct app bank", d, app_m[5]);
    rd(32'h0900_00FC, d);
    check(d === ldr_m[63], "R3 direct bootloader bank", d, ldr_m[63]);
    rd(32'h08FF_FF18, d);
    check(d === app_m[6], "R3 masked offset", d, app_m[6]);
    rd(32'h0000_00FC, d);
    rd(32'h0000_0004, d);
    rd(32'h0000_0100, d);
    check(d === 32'h0 && rsp_err === 1'b1, "R8 just past boot window", d, 32'h0);
    rd(32'h0A00_0000, d);
    check(rsp_err === 1'b1, "R8 beyond direct window", 32'(rsp_err), 32'd1);
    rd(32'h1000_0000, d);
    rd(32'hFFFF_FFFC, d);
    check(rsp_err === 1'b1 && d === 32'h0, "R8 top of space", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    run_case(1'b0, 32'h0800_0101, 1'b1, 1);   // valid image, run application
    run_case(1'b0, 32'hFFFF_FFFF, 1'b0, 2);   // R5 erased word 0 -> bootloader
    run_case(1'b1, 32'h0800_0101, 1'b0, 3);   // strap picks bootloader
    run_case(1'b0, 32'h0000_0000, 1'b1, 4);   // zeros are not erased with ones polarity
    repeat (3) @(posedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule